// File: doc/BRIEF.md
# Ethernet Transmit Framer with Automatic Padding

This block takes frame bytes from a first-word-fall-through transmit FIFO and sends them as a serial Ethernet frame, one bit per clock. It waits until the FIFO holds enough bytes and the channel is free. It then sends the preamble and the start-of-frame delimiter, followed by the frame bytes. When padding is on, it adds zero bytes so that the frame body reaches the minimum size. When the check sequence is on, it appends a CRC-32 frame check sequence.

The FIFO shows its head byte on `fifoData` together with an end-of-frame flag. The block pulls that byte with a one-cycle `fifoRead` strobe. The block assumes the whole frame is supplied without underrun once transmission has begun, so the start threshold should not exceed the frame length. Collision handling, retries and line coding belong to other blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: A frame starts only in a cycle where `chanFree` is 1, `fifoLevel` is non-zero and `fifoLevel` >= `startThresh`. While any of these is false, `txValid` stays 0 and `fifoRead` stays 0.
- R2: Each frame begins with seven bytes of value 0x55 and then the delimiter 0xD5. Each byte is sent least-significant bit first, so the line shows 1,0,1,0,... and the delimiter ends with 1,1.
- R3: After the delimiter, each FIFO byte is sent least-significant bit first, in FIFO order. One `fifoRead` pulse is given per byte. No byte is read after the byte that carries `fifoEof`.
- R4: With padding enabled, bytes of value 0x00 follow the data until data plus pad equals 60 bytes. A frame with 60 or more data bytes gets no pad.
- R5: The check sequence is the reflected CRC-32 (polynomial 0x04C11DB7, register preset to all ones, result inverted) computed over data and pad bytes. The inverted register is sent bit 0 first through bit 31, which places the highest-order coefficient first on the line.
- R6: With padding disabled, a frame shorter than 60 data bytes is sent with exactly its own bytes and no pad.
- R7: With the check sequence disabled, the frame ends right after the last data or pad bit.
- R8: `padEn` and `fcsEn` are sampled in the cycle the frame starts. Changes to them during a frame have no effect on that frame.
- R9: During and after reset, `txValid`, `txBit` and `fifoRead` are 0 until a frame starts.
- R10: `txValid` stays high without a gap from the first preamble bit to the last bit of the frame, and drops to 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| fifoData | input | 8 | Head byte of the transmit FIFO |
| fifoEof | input | 1 | Head byte is the last byte of its frame |
| fifoLevel | input | LVL_W | Number of bytes held in the FIFO |
| fifoRead | output | 1 | Pops the head byte at this clock edge |
| startThresh | input | LVL_W | Fill level needed before a frame may start |
| chanFree | input | 1 | Channel may be used |
| padEn | input | 1 | Pad short frames with zero bytes |
| fcsEn | input | 1 | Append the check sequence |
| txBit | output | 1 | Serial line bit |
| txValid | output | 1 | `txBit` carries a frame bit |

## Verification
The embedded assertions check four things on every cycle. A frame may begin only when the start condition held one cycle earlier. No FIFO read follows the end-of-frame byte. Pad bits are always zero. The CRC register is frozen outside the data and pad phases, and a padded frame enters the check-sequence phase only with a full 60-byte body. Only the bench's scenarios can show that the assembled bit stream is correct end to end. They cover preamble patterns, byte order, exact pad lengths, the check-sequence value against an independent CRC model, the enable combinations, threshold and channel gating, and mid-frame changes of the enables.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  typedef enum logic [2:0] {
    LD_NONE,
    LD_PRE,
    LD_SFD,
    LD_FIFO,
    LD_ZERO,
    LD_FCS
  } ldSel_t;

  typedef struct packed {
    logic   start;
    logic   active;
    logic   crcEn;
    logic   padBit;
    ldSel_t ldSel;
  } txStrobe_t;

endpackage

// File: rtl/eth_txf_ctrl.sv
module eth_txf_ctrl
  import eth_txf_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int LVL_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEof,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic [LVL_W-1:0] startThresh,
  input  logic             chanFree,
  input  logic             padEn,
  input  logic             fcsEn,
  output logic             fifoRead,
  output txStrobe_t        strb
);

  localparam int PRE_W = $clog2(PRE_LEN);
  localparam int CNT_W = $clog2(MIN_BODY + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_SFD, ST_DATA, ST_PAD, ST_FCS} state_t;

  state_t           state, stateNxt;
  logic [2:0]       bitCnt;
  logic [PRE_W-1:0] preCnt;
  logic [1:0]       fcsCnt;
  logic [CNT_W-1:0] bodyCnt;
  logic             lastSeen, padOn, fcsOn;
  logic             byteEnd, canStart, needPad;
  ldSel_t           ld;

  assign byteEnd  = (bitCnt == 3'd7);
  assign canStart = chanFree && (fifoLevel != '0) && (fifoLevel >= startThresh);
  assign needPad  = padOn && (bodyCnt < CNT_W'(MIN_BODY));

  always_comb begin
    stateNxt = state;
    ld       = LD_NONE;
    fifoRead = 1'b0;
    case (state)
      ST_IDLE: if (canStart) begin
        stateNxt = ST_PRE;
        ld       = LD_PRE;
      end
      ST_PRE: if (byteEnd) begin
        if (preCnt == PRE_W'(PRE_LEN - 1)) begin
          stateNxt = ST_SFD;
          ld       = LD_SFD;
        end else begin
          ld = LD_PRE;
        end
      end
      ST_SFD: if (byteEnd) begin
        stateNxt = ST_DATA;
        ld       = LD_FIFO;
        fifoRead = 1'b1;
      end
      ST_DATA, ST_PAD: if (byteEnd) begin
        if (state == ST_DATA && !lastSeen) begin
          ld       = LD_FIFO;
          fifoRead = 1'b1;
        end else if (needPad) begin
          stateNxt = ST_PAD;
          ld       = LD_ZERO;
        end else if (fcsOn) begin
          stateNxt = ST_FCS;
          ld       = LD_FCS;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_FCS: if (byteEnd && fcsCnt == 2'd3) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.start  = (state == ST_IDLE) && canStart;
    strb.active = (state != ST_IDLE);
    strb.crcEn  = (state == ST_DATA) || (state == ST_PAD);
    strb.padBit = (state == ST_PAD);
    strb.ldSel  = ld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      preCnt   <= '0;
      fcsCnt   <= '0;
      bodyCnt  <= '0;
      lastSeen <= 1'b0;
      padOn    <= 1'b0;
      fcsOn    <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= (state == ST_IDLE) ? 3'd0 : bitCnt + 3'd1;
      if (strb.start) begin
        preCnt   <= '0;
        fcsCnt   <= '0;
        bodyCnt  <= '0;
        lastSeen <= 1'b0;
        padOn    <= padEn;
        fcsOn    <= fcsEn;
      end else begin
        if (state == ST_PRE && byteEnd) preCnt <= preCnt + PRE_W'(1);
        if (state == ST_FCS && byteEnd) fcsCnt <= fcsCnt + 2'd1;
        if ((ld == LD_FIFO || ld == LD_ZERO) && bodyCnt != CNT_W'(MIN_BODY))
          bodyCnt <= bodyCnt + CNT_W'(1);
        if (fifoRead) lastSeen <= fifoEof;
      end
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.active) |-> $past(chanFree && fifoLevel != '0 && fifoLevel >= startThresh)); // R1
  AST_NO_READ_PAST_EOF: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !lastSeen); // R3
  AST_PAD_REACHES_MIN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == ST_FCS) && padOn) |-> bodyCnt == CNT_W'(MIN_BODY)); // R4

endmodule

// File: rtl/eth_txf_dp.sv
module eth_txf_dp
  import eth_txf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strb,
  input  logic [7:0] fifoData,
  output logic      txBit,
  output logic      txValid
);

  logic [31:0] shReg, crc, crcNext;
  logic        outBit;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic b);
    crcStep = {1'b0, c[31:1]} ^ ((c[0] ^ b) ? CRC_POLY_R : 32'h0);
  endfunction

  assign outBit  = shReg[0];
  assign crcNext = crcStep(crc, outBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      crc     <= '1;
      txBit   <= 1'b0;
      txValid <= 1'b0;
    end else begin
      case (strb.ldSel)
        LD_PRE:  shReg <= {24'h0, PRE_BYTE};
        LD_SFD:  shReg <= {24'h0, SFD_BYTE};
        LD_FIFO: shReg <= {24'h0, fifoData};
        LD_ZERO: shReg <= '0;
        LD_FCS:  shReg <= ~crcNext;
        default: shReg <= {1'b0, shReg[31:1]};
      endcase
      if (strb.start)      crc <= '1;
      else if (strb.crcEn) crc <= crcNext;
      txBit   <= strb.active ? outBit : 1'b0;
      txValid <= strb.active;
    end
  end

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.crcEn && !strb.start) |=> $stable(crc)); // R5
  AST_PAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.padBit |-> !outBit); // R4

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_txf_pkg::*;
#(
  parameter int PRE_LEN  = 7,
  parameter int MIN_BODY = 60,
  parameter int LVL_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       fifoData,
  input  logic             fifoEof,
  input  logic [LVL_W-1:0] fifoLevel,
  output logic             fifoRead,
  input  logic [LVL_W-1:0] startThresh,
  input  logic             chanFree,
  input  logic             padEn,
  input  logic             fcsEn,
  output logic             txBit,
  output logic             txValid
);

  txStrobe_t strb;

  eth_txf_ctrl #(.PRE_LEN(PRE_LEN), .MIN_BODY(MIN_BODY), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEof(fifoEof), .fifoLevel(fifoLevel),
    .startThresh(startThresh), .chanFree(chanFree), .padEn(padEn), .fcsEn(fcsEn),
    .fifoRead(fifoRead), .strb(strb)
  );

  eth_txf_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoData(fifoData),
    .txBit(txBit), .txValid(txValid)
  );

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!txValid && !chanFree) |-> !fifoRead); // R1

endmodule

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] fifoData;
  logic       fifoEof;
  logic [7:0] fifoLevel;
  logic       fifoRead;
  logic [7:0] startThresh = 8'd1;
  logic       chanFree = 1'b0;
  logic       padEn = 1'b0;
  logic       fcsEn = 1'b0;
  logic       txBit, txValid;

  always #2.5 clk = ~clk;

  eth_tx_framer uut (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEof(fifoEof),
    .fifoLevel(fifoLevel), .fifoRead(fifoRead), .startThresh(startThresh),
    .chanFree(chanFree), .padEn(padEn), .fcsEn(fcsEn), .txBit(txBit), .txValid(txValid)
  );

  // FIFO model
  logic [7:0] mem [256];
  logic       eofMem [256];
  int wrPtr = 0, rdPtr = 0;
  assign fifoData  = mem[rdPtr % 256];
  assign fifoEof   = eofMem[rdPtr % 256];
  assign fifoLevel = 8'(wrPtr - rdPtr);
  always @(posedge clk) if (fifoRead) rdPtr <= rdPtr + 1;

  // capture
  logic capBits [2048];
  logic expBits [2048];
  int nBits = 0, expLen = 0, cyc = 0, firstCyc = 0, lastCyc = 0;
  bit done = 0, prevValid = 0;
  int tests = 0, fails = 0;

  always @(negedge clk) begin
    cyc++;
    if (txValid) begin
      if (nBits < 2048) capBits[nBits] = txBit;
      if (nBits == 0) firstCyc = cyc;
      lastCyc = cyc;
      nBits++;
    end
    if (prevValid && !txValid) done = 1;
    prevValid = txValid;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
    summary();
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dByte(int f, int k);
    return 8'(f * 37 + k * 11 + 3);
  endfunction

  task automatic putByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      expBits[expLen] = b[i];
      expLen++;
    end
  endtask

  int curLen, curBody;
  bit curPad, curFcs;

  task automatic prep(int f, int len, int thr, bit pad, bit fcs);
    logic [31:0] crc;
    logic [7:0] b;
    @(negedge clk);
    padEn = pad; fcsEn = fcs; startThresh = 8'(thr);
    curLen = len; curPad = pad; curFcs = fcs;
    curBody = (pad && len < 60) ? 60 : len;
    for (int k = 0; k < len; k++) begin
      mem[wrPtr % 256]    = dByte(f, k);
      eofMem[wrPtr % 256] = (k == len - 1);
      wrPtr++;
    end
    expLen = 0;
    for (int k = 0; k < 7; k++) putByte(8'h55);
    putByte(8'hD5);
    crc = '1;
    for (int k = 0; k < curBody; k++) begin
      b = (k < len) ? dByte(f, k) : 8'h00;
      putByte(b);
      for (int i = 0; i < 8; i++) begin
        if (crc[0] ^ b[i]) crc = {1'b0, crc[31:1]} ^ 32'hEDB88320;
        else               crc = {1'b0, crc[31:1]};
      end
    end
    if (fcs) for (int i = 0; i < 32; i++) begin
      expBits[expLen] = ~crc[i];
      expLen++;
    end
    @(posedge clk);
    nBits = 0; done = 0;
  endtask

  task automatic waitDone(string tag);
    int t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done, {tag, " frame completes"}, t, 5000);
  endtask

  function automatic int mism(int lo, int hi);
    int m = 0;
    for (int i = lo; i < hi; i++) if (i < nBits && capBits[i] !== expBits[i]) m++;
    return m;
  endfunction

  task automatic checkFrame();
    string lenTag, bodyTag;
    int m;
    lenTag  = !curFcs ? "R7 length" : (curPad ? "R4 length" : "R6 length");
    bodyTag = (curBody > curLen) ? "R4 body with pad" : "R3 body";
    chk(nBits == expLen, lenTag, nBits, expLen);
    m = mism(0, 64);
    chk(m == 0, "R2 preamble/delimiter bit mismatches", m, 0);
    m = mism(64, 64 + 8 * curBody);
    chk(m == 0, {bodyTag, " bit mismatches"}, m, 0);
    if (curFcs) begin
      m = mism(64 + 8 * curBody, expLen);
      chk(m == 0, "R5 check sequence bit mismatches", m, 0);
    end
    chk(lastCyc - firstCyc + 1 == nBits, "R10 txValid contiguous", lastCyc - firstCyc + 1, nBits);
    chk(rdPtr == wrPtr, "R3 bytes read equals frame length", rdPtr, wrPtr);
  endtask

  // {len, thr, pad, fcs}
  localparam logic [23:0] VEC [6] = '{
    {8'd20, 8'd4,  4'h1, 4'h1},
    {8'd60, 8'd8,  4'h1, 4'h1},
    {8'd64, 8'd16, 4'h0, 4'h1},
    {8'd10, 8'd2,  4'h0, 4'h1},
    {8'd30, 8'd4,  4'h1, 4'h0},
    {8'd12, 8'd1,  4'h0, 4'h0}
  };

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      eofMem[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(txValid == 0 && fifoRead == 0 && txBit == 0, "R9 outputs idle in reset", {txValid, fifoRead, txBit}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(txValid == 0 && fifoRead == 0, "R9 outputs idle after reset", {txValid, fifoRead}, 0);

    for (int v = 0; v < 6; v++) begin
      prep(v, int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][4], VEC[v][0]);
      @(negedge clk);
      chanFree = 1'b1;
      waitDone("vector");
      chanFree = 1'b0;
      checkFrame();
    end

    // R1: channel gating, then threshold gating
    prep(7, 5, 5, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    chk(nBits == 0 && rdPtr != wrPtr, "R1 no start while channel busy", nBits, 0);
    startThresh = 8'd8;
    chanFree = 1'b1;
    repeat (40) @(negedge clk);
    chk(nBits == 0 && rdPtr != wrPtr, "R1 no start below threshold", nBits, 0);
    startThresh = 8'd5;
    waitDone("R1");
    chanFree = 1'b0;
    checkFrame();

    // R8: enables changed mid-frame are ignored
    prep(8, 15, 3, 1'b1, 1'b1);
    @(negedge clk);
    chanFree = 1'b1;
    while (!txValid) @(negedge clk);
    padEn = 1'b0; fcsEn = 1'b0;
    waitDone("R8");
    chanFree = 1'b0;
    chk(nBits == expLen, "R8 enables latched at start (length)", nBits, expLen);
    checkFrame();

    repeat (5) @(negedge clk);
    chk(txValid == 0 && fifoRead == 0, "R10 idle after frame", {txValid, fifoRead}, 0);
    summary();
  end

endmodule